// File: doc/BRIEF.md
# Serial-Bus Byte Memory Target

This block is a target on a two-wire serial bus, of the SMBus or I2C kind. Behind it sits a 128-byte register array. The block oversamples the clock and data lines with its own system clock. It detects start and stop conditions and answers only to its own 7-bit device address. It drives the data line through an open-drain enable.

A host reads the array in three ways:
- A current-address read returns the byte at an internal pointer.
- A random read first loads the pointer with a write transaction that carries only a word address. A repeated start and a read follow.
- Either kind of read continues as a sequential read while the host acknowledges each byte.

A host writes either one byte or a run of bytes that stays inside an 8-byte page. An active-high protect input blocks every change to stored data. Under protection, write bytes are still acknowledged and the pointer still advances.

Top module: `smb_eeprom_slave`

## Requirements
- R1: The array holds 128 bytes. Of the 8-bit word address sent by the host, bit 7 is ignored and bits 6:0 select the byte.
- R2: The block acknowledges only a device byte whose upper 7 bits equal the parameter `SLV_ADDR`; bit 0 is the direction (0 write, 1 read). On a mismatch it leaves the data line released for the rest of the transaction.
- R3: In a write transaction, the first byte after the device byte is the word address. Every later byte is stored at the pointer, and the block acknowledges the word address and each data byte.
- R4: After each data byte that is written, pointer bits 2:0 increment modulo 8 and bits 6:3 are held. More than 8 bytes in one transaction therefore overwrite earlier bytes of the same page.
- R5: A current-address read returns the byte at the pointer, and the pointer always sits one past the byte most recently read or written.
- R6: A write transaction that ends after the word address, by a stop or a repeated start, loads the pointer with that address. A following read starts there.
- R7: A read keeps returning successive bytes, most significant bit first, while the host acknowledges each one. The pointer steps by one per byte and wraps from 127 to 0.
- R8: A host NACK after a read byte ends the read. The block releases the data line until the next start.
- R9: While the protect input is high, data bytes are acknowledged but no stored byte changes, and the pointer still advances as in R4.
- R10: A stop returns the block to idle with the data line released. A start or repeated start at any bit restarts device-address reception. A partly received data byte is discarded.
- R11: The block changes its drive of the data line only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| wp_i | input | 1 | Write protect, active high (tie low when unused) |
| sda_oe_o | output | 1 | Pull the data line low when 1, release when 0 |

## Verification
The whole array is first filled through sixteen page writes with an arithmetic pattern. It is then read back in one sequential burst of 130 bytes that starts at address 0, which shows both the per-byte stepping and the wrap from 127 to 0. Separate patterns cover the remaining behaviour:
- A word address with bit 7 set, to show that the bit is ignored.
- An 11-byte page write starting mid-page, to show the page-local wrap and the overwrite.
- A protected write followed by a current-address read, to show that data stays and the pointer moves.
- A foreign device address, which must draw no acknowledge.
- A data byte cut short by a repeated start, which must store nothing and keep the loaded pointer.

// File: rtl/smb_eeprom_pkg.sv
package smb_eeprom_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_DEVACK,
    ST_WORD,
    ST_WORDACK,
    ST_WDATA,
    ST_WDACK,
    ST_RDATA,
    ST_RACK
  } smb_state_e;

  localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/smb_bus_sampler.sv
module smb_bus_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_m, sda_m, scl_p, sda_p;

  // two-flop synchronizers plus one history stage; idle bus reads high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1;
      scl_s <= 1'b1;
      scl_p <= 1'b1;
      sda_m <= 1'b1;
      sda_s <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_m <= scl_i;
      scl_s <= scl_m;
      scl_p <= scl_s;
      sda_m <= sda_i;
      sda_s <= sda_m;
      sda_p <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_p;
    scl_fall  = ~scl_s & scl_p;
    start_det = scl_s & scl_p & sda_p & ~sda_s;
    stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  end

endmodule

// File: rtl/smb_byte_array.sv
module smb_byte_array #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_i,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_comb rdata = mem_q[raddr];

  // R9: no write strobe reaches the array while protect is high
  p_wp_blocks_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> !wp_i);

endmodule

// File: rtl/smb_eeprom_ctrl.sv
module smb_eeprom_ctrl
  import smb_eeprom_pkg::*;
#(
  parameter logic [6:0]  SLV_ADDR   = 7'h50,
  parameter int unsigned DEPTH      = 128,
  parameter int unsigned PAGE_BYTES = 8,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PAGE_W = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          wp_i,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  output logic          sda_oe
);

  localparam logic [3:0]        BITS_FULL = 4'(BYTE_BITS);
  localparam logic [3:0]        LAST_BIT  = 4'(BYTE_BITS - 1);
  localparam logic [AW-1:0]     ONE_A     = 1;
  localparam logic [PAGE_W-1:0] ONE_P     = 1;

  smb_state_e    state_q, state_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [7:0]    shreg_q, shreg_d;
  logic [7:0]    txreg_q, txreg_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          rw_q, rw_d;
  logic          oe_q, oe_d;
  logic          mack_q, mack_d;
  logic          rx_state;

  always_comb begin
    rx_state = (state_q == ST_DEVADR) || (state_q == ST_WORD) ||
               (state_q == ST_WDATA);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    txreg_d = txreg_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    mem_we  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_DEVADR;
      cnt_d   = 4'd0;
      oe_d    = 1'b0;
    end else if (rx_state) begin
      if (scl_rise && cnt_q != BITS_FULL) begin
        shreg_d = {shreg_q[6:0], sda_s};
        cnt_d   = cnt_q + 4'd1;
      end else if (scl_fall && cnt_q == BITS_FULL) begin
        unique case (state_q)
          ST_DEVADR: begin
            if (shreg_q[7:1] == SLV_ADDR) begin
              state_d = ST_DEVACK;
              rw_d    = shreg_q[0];
              oe_d    = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end
          ST_WORD: begin
            ptr_d   = shreg_q[AW-1:0];
            state_d = ST_WORDACK;
            oe_d    = 1'b1;
          end
          default: begin
            mem_we  = ~wp_i;
            ptr_d   = {ptr_q[AW-1:PAGE_W], ptr_q[PAGE_W-1:0] + ONE_P};
            state_d = ST_WDACK;
            oe_d    = 1'b1;
          end
        endcase
      end
    end else begin
      unique case (state_q)
        ST_DEVACK: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if (rw_q) begin
              state_d = ST_RDATA;
              txreg_d = mem_rdata;
              oe_d    = ~mem_rdata[7];
            end else begin
              state_d = ST_WORD;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WORDACK, ST_WDACK: begin
          if (scl_fall) begin
            state_d = ST_WDATA;
            cnt_d   = 4'd0;
            oe_d    = 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              state_d = ST_RACK;
              oe_d    = 1'b0;
              ptr_d   = ptr_q + ONE_A;
            end else begin
              txreg_d = {txreg_q[6:0], txreg_q[7]};
              oe_d    = ~txreg_q[6];
              cnt_d   = cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDATA;
              txreg_d = mem_rdata;
              oe_d    = ~mem_rdata[7];
              cnt_d   = 4'd0;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 4'd0;
      shreg_q <= 8'd0;
      txreg_q <= 8'd0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      txreg_q <= txreg_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
    end
  end

  always_comb begin
    mem_addr  = ptr_q;
    mem_wdata = shreg_q;
    sda_oe    = oe_q;
  end

  // R11: the drive may only toggle while the sampled clock line is low
  p_oe_toggle_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !scl_s);

  // R10: a detected stop leaves the block idle with the line released
  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!oe_q && state_q == ST_IDLE));

  // R4: a committed data byte keeps the page bits of the pointer
  p_page_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (ptr_q[AW-1:PAGE_W] == $past(ptr_q[AW-1:PAGE_W])));

  // R2: while acknowledging a matched device byte the line is pulled low
  p_ack_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DEVACK) |-> oe_q);

  // R8: after the host acknowledge slot the drive is released unless a byte restarts
  p_rack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RACK) |-> !oe_q);

endmodule

// File: rtl/smb_eeprom_slave.sv
module smb_eeprom_slave #(
  parameter logic [6:0]  SLV_ADDR   = 7'h50,
  parameter int unsigned MEM_BYTES  = 128,
  parameter int unsigned PAGE_BYTES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o
);

  localparam int unsigned AW = $clog2(MEM_BYTES);

  logic          rst_meta, rst_sync;
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  smb_bus_sampler u_sampler (
    .clk       (clk),
    .rst_n     (rst_sync),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_eeprom_ctrl #(
    .SLV_ADDR   (SLV_ADDR),
    .DEPTH      (MEM_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .wp_i      (wp_i),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .sda_oe    (sda_oe_o)
  );

  smb_byte_array #(
    .DEPTH (MEM_BYTES)
  ) u_array (
    .clk   (clk),
    .rst_n (rst_sync),
    .wp_i  (wp_i),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (mem_wdata),
    .raddr (mem_addr),
    .rdata (mem_rdata)
  );

endmodule

// File: tb/smb_eeprom_slave_tb_top.sv
module smb_eeprom_slave_tb_top;

  localparam logic [6:0] SA = 7'h50;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  wire  sda_bus = sda_h & ~sda_oe;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] model_q [128];
  logic [6:0] ptr_m = 7'd0;
  logic [7:0] buf_q [16];

  always #10 clk = ~clk;

  smb_eeprom_slave #(.SLV_ADDR(SA)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_h),
    .sda_i    (sda_bus),
    .wp_i     (wp),
    .sda_oe_o (sda_oe)
  );

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; wq();
    scl_h = 1'b1; wq();
    sda_h = 1'b0; wq();
    scl_h = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq();
    scl_h = 1'b1; wq();
    sda_h = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_h = b; wq();
    scl_h = 1'b1; wq();
    scl_h = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_h = 1'b1; wq();
    scl_h = 1'b1; wq();
    acked = ~sda_bus;
    scl_h = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] d);
    sda_h = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq();
      scl_h = 1'b1; wq();
      d[i] = sda_bus;
      scl_h = 1'b0;
    end
    wq();
    sda_h = ~mack; wq();
    scl_h = 1'b1; wq();
    scl_h = 1'b0; wq();
    sda_h = 1'b1;
  endtask

  // write transaction: word address then n data bytes from buf_q
  task automatic page_write(input logic [7:0] waddr, input int n, input string tag);
    logic a;
    bus_start();
    send_byte({SA, 1'b0}, a); chk(a, "R2 device ack", a, 1);
    send_byte(waddr, a);      chk(a, "R3 word ack", a, 1);
    ptr_m = waddr[6:0];
    for (int i = 0; i < n; i++) begin
      send_byte(buf_q[i], a); chk(a, tag, a, 1);
      if (!wp) model_q[ptr_m] = buf_q[i];
      ptr_m = {ptr_m[6:3], ptr_m[2:0] + 3'd1};
    end
    bus_stop();
  endtask

  // read n bytes; random read first when rnd is set
  task automatic read_run(input bit rnd, input logic [7:0] waddr, input int n, input string tag);
    logic a;
    logic [7:0] d;
    bus_start();
    if (rnd) begin
      send_byte({SA, 1'b0}, a); chk(a, "R6 device ack", a, 1);
      send_byte(waddr, a);      chk(a, "R6 word ack", a, 1);
      ptr_m = waddr[6:0];
      bus_start();
    end
    send_byte({SA, 1'b1}, a); chk(a, "R2 read device ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == model_q[ptr_m], tag, d, model_q[ptr_m]);
      ptr_m = ptr_m + 7'd1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: released line after reset
    chk(sda_oe == 1'b0, "R10 reset release", sda_oe, 0);

    // R3 R4: fill the whole array with 16 page writes
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 8; i++) buf_q[i] = pat(p * 8 + i, 0);
      page_write(8'(p * 8), 8, "R3 data ack");
    end
    // R7: 130-byte sequential read from 0 with wrap
    read_run(1'b1, 8'h00, 130, "R7 sequential read");
    chk(ptr_m == 7'd2, "R7 wrap pointer", ptr_m, 2);

    // R1: word address bit 7 ignored
    buf_q[0] = 8'hA5;
    page_write(8'h85, 1, "R1 data ack");
    read_run(1'b1, 8'h05, 1, "R1 byte at 0x05");
    chk(model_q[5] == 8'hA5, "R1 model", model_q[5], 8'hA5);
    // R5: current-address read follows the last read
    read_run(1'b0, 8'h00, 1, "R5 current read");
    chk(ptr_m == 7'd7, "R5 pointer", ptr_m, 7);

    // R4: 11 bytes from 0x1D wrap inside page 0x18..0x1F
    for (int i = 0; i < 11; i++) buf_q[i] = pat(i, 3);
    page_write(8'h1D, 11, "R4 data ack");
    chk(ptr_m == 7'h18, "R4 wrapped pointer", ptr_m, 8'h18);
    read_run(1'b0, 8'h00, 1, "R4 current read after page wrap");
    read_run(1'b1, 8'h18, 8, "R4 page contents");
    chk(model_q[8'h1D] == pat(8, 3), "R4 overwrite", model_q[8'h1D], pat(8, 3));

    // R9: protected write acked, data kept, pointer moves
    wp = 1'b1;
    for (int i = 0; i < 3; i++) buf_q[i] = ~model_q[8'h40 + i];
    page_write(8'h40, 3, "R9 protected ack");
    wp = 1'b0;
    chk(ptr_m == 7'h43, "R9 pointer", ptr_m, 8'h43);
    read_run(1'b0, 8'h00, 1, "R9 current read after protected write");
    read_run(1'b1, 8'h40, 3, "R9 protected data unchanged");

    // R2: foreign device address is not acknowledged
    bus_start();
    send_byte({7'h51, 1'b0}, a); chk(!a, "R2 foreign no ack", a, 0);
    send_byte(8'h12, a);         chk(!a, "R2 ignored byte", a, 0);
    bus_stop();
    read_run(1'b1, 8'h12, 1, "R2 byte untouched");

    // R6: word-only write then stop loads pointer
    bus_start();
    send_byte({SA, 1'b0}, a); send_byte(8'h30, a);
    bus_stop();
    ptr_m = 7'h30;
    read_run(1'b0, 8'h00, 1, "R6 pointer load by stop");

    // R10: repeated start mid data byte discards it
    bus_start();
    send_byte({SA, 1'b0}, a); send_byte(8'h50, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_start();
    ptr_m = 7'h50;
    send_byte({SA, 1'b1}, a); chk(a, "R10 restart ack", a, 1);
    recv_byte(1'b0, d);
    chk(d == model_q[8'h50], "R10 partial byte discarded", d, model_q[8'h50]);
    // R8: NACK released the line
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R8 release after nack", sda_oe, 0);
    bus_stop();
    chk(sda_oe == 1'b0, "R11 idle line", sda_oe, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule